// File: doc/BRIEF.md
# Register Hazard Stall Interlock

This block sits at the issue point of a small in-order scalar pipeline. It works out how many cycles an instruction has to wait before it may issue. Each instruction is offered on a valid/ready handshake. It carries a destination register with the width written, the registers it reads for address calculation and as data, a flag saying whether the address fields are really used to form an address, and its base cycle count.

For every register the block tracks two things: how recently a write to it finished, and whether that write touched only one byte. Two independent one-cycle penalties come from this state. The first is an address-generation interlock, raised when a register is used to form an address directly after it was written. The second is a partial-register flow break, raised when one of the four byte-addressable registers is read at full width directly after a byte write. The penalties for one operand add. Each cycle that has passed since the write removes one penalty cycle, not both at once. The stall is the largest remainder over all source operands. The block reports that stall, a one-cycle issue strobe, and a free-running cycle counter.

Top module: `hazard_interlock`

## Requirements
- R1: During and after reset: `inReady` is 1, `stallCount` is 0, `issuePulse` is 0 and `cycleCount` is 0. No write is remembered, so the first instructions see no stall.
- R2: An instruction that reads, as data, a register fully written by the instruction just before it gets a stall of 0. One-cycle instructions can then be accepted in consecutive cycles.
- R3: With `agenUse` = 1, reading any of the eight registers (IDs 0..7) through `addrSrc` in the cycle after its write has completed gives a stall of 1 (address-generation interlock).
- R4: With `agenUse` = 0, the `addrSrc` registers are treated as plain data reads and never raise the address-generation interlock.
- R5: Width codes are 00 no write, 01 low byte, 10 high byte and 11 full. A byte write (01 or 10) to register 0..3, followed directly by a full-width read of that register, gives a stall of 1 (flow break). A byte write to registers 4..7 counts as a full write.
- R6: When both penalties hit the same operand, they add. An address read directly after a byte write to that register stalls 2, so a one-cycle instruction takes 3 cycles.
- R7: Each cycle between the write's completion and the reader's acceptance cancels one penalty cycle. One idle or one-cycle instruction in between leaves 1 of 2. Two such cycles, or one two-cycle instruction, leave 0.
- R8: A full-width write clears the pending byte-write state of a register. Only the address-generation interlock can then remain.
- R9: The reported stall is the maximum over all valid source operands, each computed on its own.
- R10: After an accept in cycle t with stall s and base b (a base of 0 is taken as 1): `stallCount` shows s from cycle t+1 and holds until the next accept. `issuePulse` is 1 only in cycle t+s+1. `inReady` is low in cycles t+1 through t+s+b-1.
- R11: `cycleCount` increases by one on every clock after reset and wraps at its width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An instruction is offered |
| inReady | output | 1 | Block can accept an instruction this cycle |
| dstReg | input | REG_W | Destination register ID |
| dstWidth | input | 2 | Write width: 00 none, 01 low byte, 10 high byte, 11 full |
| addrSrc | input | NUM_ADDR x REG_W | Registers used for address calculation |
| addrVld | input | NUM_ADDR | Valid bit per address source |
| dataSrc | input | NUM_DATA x REG_W | Registers read as data (full width) |
| dataVld | input | NUM_DATA | Valid bit per data source |
| agenUse | input | 1 | Address sources really form an address (loads, stores, address-calculation) |
| baseCycles | input | BASE_W | Execution cycles of the instruction |
| stallCount | output | 2 | Stall of the last accepted instruction |
| issuePulse | output | 1 | One-cycle strobe in the cycle the instruction issues |
| cycleCount | output | CNT_W | Free-running cycle counter |

## Verification
Each result has a fixed latency after the accepting edge in cycle t. The stall appears in cycle t+1. The issue strobe falls in cycle t+s+1. The next accept can happen no earlier than cycle t+s+b. The driver keeps its own cycle count and a model of per-register write completion times, and from these it predicts both the stall and the exact cycle of each issue strobe. A monitor samples on the falling edge, matches each strobe against the oldest predicted issue, and compares the stall and the cycle number there. The driver also checks that every offer is accepted exactly when the model says the unit becomes free.

// File: rtl/ilk_pkg.sv
`timescale 1ns/1ps
package ilk_pkg;

  // Destination write width encoding
  typedef enum logic [1:0] {
    WID_NONE = 2'b00,
    WID_LO   = 2'b01,
    WID_HI   = 2'b10,
    WID_FULL = 2'b11
  } wid_e;

  // Most penalty cycles a single operand can collect
  localparam int MAX_PEN = 2;

  // Strobes from the sequencer to the scoreboard
  typedef struct packed {
    logic recordWrite;  // accepted instruction writes its destination
    logic byteWrite;    // the write covers a single byte
  } ilkStrobes_t;

endpackage

// File: rtl/ilk_scoreboard.sv
`timescale 1ns/1ps
module ilk_scoreboard #(
  parameter int NUM_REGS      = 8,
  parameter int REG_W         = 3,
  parameter int NUM_ADDR      = 2,
  parameter int NUM_DATA      = 2,
  parameter int BASE_W        = 4,
  parameter int NUM_BYTE_REGS = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ilk_pkg::ilkStrobes_t             strobes,
  input  logic [REG_W-1:0]                 dstReg,
  input  logic [NUM_ADDR-1:0][REG_W-1:0]   addrSrc,
  input  logic [NUM_ADDR-1:0]              addrVld,
  input  logic [NUM_DATA-1:0][REG_W-1:0]   dataSrc,
  input  logic [NUM_DATA-1:0]              dataVld,
  input  logic                             agenUse,
  input  logic [BASE_W-1:0]                baseEff,
  output logic [1:0]                       stallCalc
);
  import ilk_pkg::*;

  localparam int NUM_SRC = NUM_ADDR + NUM_DATA;
  localparam int AGE_W   = BASE_W + 2;

  // ageLeft = cycles until write completion, plus MAX_PEN, floored at zero
  logic [AGE_W-1:0] ageLeft [NUM_REGS];
  logic             partialQ [NUM_REGS];

  logic [REG_W-1:0] srcReg   [NUM_SRC];
  logic             srcVld   [NUM_SRC];
  logic             srcAgi   [NUM_SRC];
  logic [1:0]       srcStall [NUM_SRC];

  // Flatten the address and data operand lists into one source list
  for (genvar a = 0; a < NUM_ADDR; a++) begin : gAddr
    assign srcReg[a] = addrSrc[a];
    assign srcVld[a] = addrVld[a];
    assign srcAgi[a] = agenUse;
  end

  for (genvar d = 0; d < NUM_DATA; d++) begin : gData
    assign srcReg[NUM_ADDR+d] = dataSrc[d];
    assign srcVld[NUM_ADDR+d] = dataVld[d];
    assign srcAgi[NUM_ADDR+d] = 1'b0;
  end

  // Per-source remaining stall: max(0, penalties - elapsed cycles)
  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
    logic [1:0] pen;
    logic [1:0] near;
    logic [2:0] sum;
    always_comb begin
      pen  = 2'(srcAgi[s]) + 2'(partialQ[srcReg[s]]);
      near = (ageLeft[srcReg[s]] > AGE_W'(MAX_PEN)) ? 2'(MAX_PEN)
                                                    : ageLeft[srcReg[s]][1:0];
      sum  = 3'(pen) + 3'(near);
      if (srcVld[s] && (sum > 3'(MAX_PEN)))
        srcStall[s] = 2'(sum - 3'(MAX_PEN));
      else
        srcStall[s] = 2'd0;
    end
  end

  // Largest stall over all sources
  always_comb begin
    stallCalc = 2'd0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (srcStall[s] > stallCalc) stallCalc = srcStall[s];
    end
  end

  // Per-register write history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        ageLeft[r]  <= '0;
        partialQ[r] <= 1'b0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strobes.recordWrite && (dstReg == REG_W'(r))) begin
          ageLeft[r]  <= AGE_W'(stallCalc) + AGE_W'(baseEff) + AGE_W'(1);
          partialQ[r] <= strobes.byteWrite && (r < NUM_BYTE_REGS);
        end else if (ageLeft[r] != '0) begin
          ageLeft[r] <= ageLeft[r] - AGE_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/ilk_sequencer.sv
`timescale 1ns/1ps
module ilk_sequencer #(
  parameter int BASE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           dstWidth,
  input  logic [1:0]           stallCalc,
  input  logic [BASE_W-1:0]    baseEff,
  output ilk_pkg::ilkStrobes_t strobes,
  output logic                 accept,
  output logic                 inReady,
  output logic [1:0]           stallCount,
  output logic                 issuePulse,
  output logic [CNT_W-1:0]     cycleCount
);
  import ilk_pkg::*;

  localparam int BUSY_W = BASE_W + 2;

  logic [BUSY_W-1:0] busyCnt;
  logic              pendQ;
  logic [1:0]        waitQ;

  assign inReady    = (busyCnt == '0);
  assign accept     = inValid && inReady;
  assign issuePulse = pendQ && (waitQ == 2'd0);

  always_comb begin
    strobes.recordWrite = accept && (dstWidth != WID_NONE);
    strobes.byteWrite   = (dstWidth == WID_LO) || (dstWidth == WID_HI);
  end

  // Occupancy: stall cycles plus execution cycles, minus the accept cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      busyCnt <= '0;
    else if (accept)
      busyCnt <= BUSY_W'(stallCalc) + BUSY_W'(baseEff) - BUSY_W'(1);
    else if (busyCnt != '0)
      busyCnt <= busyCnt - BUSY_W'(1);
  end

  // Issue strobe timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      waitQ <= 2'd0;
    end else if (accept) begin
      pendQ <= 1'b1;
      waitQ <= stallCalc;
    end else if (pendQ) begin
      if (waitQ == 2'd0) pendQ <= 1'b0;
      else               waitQ <= waitQ - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       stallCount <= 2'd0;
    else if (accept) stallCount <= stallCalc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycleCount <= '0;
    else       cycleCount <= cycleCount + CNT_W'(1);
  end

endmodule

// File: rtl/hazard_interlock.sv
`timescale 1ns/1ps
module hazard_interlock #(
  parameter int NUM_REGS      = 8,
  parameter int REG_W         = 3,
  parameter int NUM_ADDR      = 2,
  parameter int NUM_DATA      = 2,
  parameter int BASE_W        = 4,
  parameter int CNT_W         = 16,
  parameter int NUM_BYTE_REGS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  output logic                           inReady,
  input  logic [REG_W-1:0]               dstReg,
  input  logic [1:0]                     dstWidth,
  input  logic [NUM_ADDR-1:0][REG_W-1:0] addrSrc,
  input  logic [NUM_ADDR-1:0]            addrVld,
  input  logic [NUM_DATA-1:0][REG_W-1:0] dataSrc,
  input  logic [NUM_DATA-1:0]            dataVld,
  input  logic                           agenUse,
  input  logic [BASE_W-1:0]              baseCycles,
  output logic [1:0]                     stallCount,
  output logic                           issuePulse,
  output logic [CNT_W-1:0]               cycleCount
);
  import ilk_pkg::*;

  ilkStrobes_t       strobes;
  logic [1:0]        stallCalc;
  logic [BASE_W-1:0] baseEff;
  logic              accept;

  // A zero base count behaves as one cycle
  assign baseEff = (baseCycles == '0) ? BASE_W'(1) : baseCycles;

  ilk_scoreboard #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .NUM_ADDR(NUM_ADDR),
    .NUM_DATA(NUM_DATA), .BASE_W(BASE_W), .NUM_BYTE_REGS(NUM_BYTE_REGS)
  ) uBoard (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dstReg(dstReg),
    .addrSrc(addrSrc), .addrVld(addrVld), .dataSrc(dataSrc), .dataVld(dataVld),
    .agenUse(agenUse), .baseEff(baseEff), .stallCalc(stallCalc)
  );

  ilk_sequencer #(.BASE_W(BASE_W), .CNT_W(CNT_W)) uSeq (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dstWidth(dstWidth),
    .stallCalc(stallCalc), .baseEff(baseEff), .strobes(strobes),
    .accept(accept), .inReady(inReady), .stallCount(stallCount),
    .issuePulse(issuePulse), .cycleCount(cycleCount)
  );

endmodule

// File: rtl/ilk_checker.sv
`timescale 1ns/1ps
module ilk_checker #(
  parameter int BASE_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [BASE_W-1:0] baseCycles,
  input logic [1:0]        stallCount,
  input logic              issuePulse,
  input logic [CNT_W-1:0]  cycleCount,
  input logic [1:0]        stallCalc
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cycleCount == CNT_W'($past(cycleCount) + CNT_W'(1))); // R11

  AST_STALL_MAX: assert property (@(posedge clk) disable iff (!rstN)
    stallCount <= 2'd2); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> $stable(stallCount)); // R10

  AST_ZERO_STALL_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && stallCalc == 2'd0) |=> issuePulse); // R10

  AST_STALL_DEFERS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && stallCalc != 2'd0) |=> (!issuePulse && !inReady)); // R10

  AST_MULTI_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && baseCycles > BASE_W'(1)) |=> !inReady); // R10

endmodule

bind hazard_interlock ilk_checker #(.BASE_W(BASE_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .baseCycles(baseCycles), .stallCount(stallCount), .issuePulse(issuePulse),
  .cycleCount(cycleCount), .stallCalc(stallCalc)
);

// File: tb/sim_hazard_interlock.sv
`timescale 1ns/1ps
module sim_hazard_interlock;

  localparam int REG_W  = 3;
  localparam int BASE_W = 4;
  localparam int CNT_W  = 16;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   inValid = 1'b0;
  logic                   inReady;
  logic [REG_W-1:0]       dstReg = '0;
  logic [1:0]             dstWidth = 2'b00;
  logic [1:0][REG_W-1:0]  addrSrc = '0;
  logic [1:0]             addrVld = '0;
  logic [1:0][REG_W-1:0]  dataSrc = '0;
  logic [1:0]             dataVld = '0;
  logic                   agenUse = 1'b0;
  logic [BASE_W-1:0]      baseCycles = '0;
  logic [1:0]             stallCount;
  logic                   issuePulse;
  logic [CNT_W-1:0]       cycleCount;

  always #4 clk = ~clk;  // 125 MHz

  hazard_interlock u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .dstReg(dstReg), .dstWidth(dstWidth), .addrSrc(addrSrc), .addrVld(addrVld),
    .dataSrc(dataSrc), .dataVld(dataVld), .agenUse(agenUse),
    .baseCycles(baseCycles), .stallCount(stallCount), .issuePulse(issuePulse),
    .cycleCount(cycleCount)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench cycle count: 0 in reset, +1 per clock afterwards
  int benchCyc = 0;
  always @(posedge clk) begin
    if (!rstN) benchCyc <= 0;
    else       benchCyc <= benchCyc + 1;
  end

  // Reference model state
  int  doneAt [8];
  bit  partial [8];
  int  freeAt = 0;

  typedef struct {
    int    stall;
    int    issueAt;
    string tag;
  } exp_t;
  exp_t expQ[$];

  function automatic int srcStall(input int r, input bit agi);
    int pen;
    int el;
    pen = (agi ? 1 : 0) + ((r < 4 && partial[r]) ? 1 : 0);
    el  = benchCyc - doneAt[r];
    return (pen - el > 0) ? pen - el : 0;
  endfunction

  // Driver: present one instruction, predict its stall and issue cycle
  task automatic send(input int dst, input int width, input int a0, input int a1,
                      input int d0, input int d1, input bit agen, input int base,
                      input string tag);
    int presentAt;
    int st;
    int s;
    int be;
    exp_t e;
    @(negedge clk);
    dstReg     = REG_W'(dst);
    dstWidth   = 2'(width);
    addrSrc[0] = REG_W'(a0 < 0 ? 0 : a0);
    addrSrc[1] = REG_W'(a1 < 0 ? 0 : a1);
    addrVld    = {a1 >= 0, a0 >= 0};
    dataSrc[0] = REG_W'(d0 < 0 ? 0 : d0);
    dataSrc[1] = REG_W'(d1 < 0 ? 0 : d1);
    dataVld    = {d1 >= 0, d0 >= 0};
    agenUse    = agen;
    baseCycles = BASE_W'(base);
    inValid    = 1'b1;
    presentAt  = benchCyc;
    while (!inReady) @(negedge clk);
    check(benchCyc == ((presentAt > freeAt) ? presentAt : freeAt), "R10",
          {tag, " accept cycle"}, benchCyc, (presentAt > freeAt) ? presentAt : freeAt);
    st = 0;
    if (a0 >= 0) begin s = srcStall(a0, agen); if (s > st) st = s; end
    if (a1 >= 0) begin s = srcStall(a1, agen); if (s > st) st = s; end
    if (d0 >= 0) begin s = srcStall(d0, 1'b0); if (s > st) st = s; end
    if (d1 >= 0) begin s = srcStall(d1, 1'b0); if (s > st) st = s; end
    be = (base == 0) ? 1 : base;
    e.stall   = st;
    e.issueAt = benchCyc + st + 1;
    e.tag     = tag;
    expQ.push_back(e);
    freeAt = benchCyc + st + be;
    if (width != 0) begin
      doneAt[dst]  = benchCyc + st + be;
      partial[dst] = (width == 1 || width == 2);
    end
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic wr(input int dst, input int width, input int base, input string tag);
    send(dst, width, -1, -1, -1, -1, 1'b0, base, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected stall values the scenarios rely on (cross-check of the model)
  task automatic expectStall(input int v, input string req);
    check(expQ.size() > 0 && expQ[$].stall == v, req, "predicted stall",
          expQ.size() > 0 ? expQ[$].stall : -1, v);
  endtask

  // Monitor: match each issue strobe against the oldest prediction
  always @(negedge clk) begin
    if (rstN && issuePulse && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected issue strobe", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(int'(stallCount) == e.stall, e.tag, "stall count", stallCount, e.stall);
        check(benchCyc == e.issueAt, "R10", {e.tag, " issue cycle"}, benchCyc, e.issueAt);
        check(int'(cycleCount) == benchCyc, "R11", "cycle counter", cycleCount, benchCyc);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) begin doneAt[r] = -100; partial[r] = 1'b0; end
    idle(3);
    check(inReady == 1'b1, "R1", "inReady in reset", inReady, 1);
    check(stallCount == 2'd0, "R1", "stallCount in reset", stallCount, 0);
    check(issuePulse == 1'b0, "R1", "issuePulse in reset", issuePulse, 0);
    check(cycleCount == '0, "R1", "cycleCount in reset", cycleCount, 0);
    rstN = 1'b1;
    idle(2);
    check(int'(cycleCount) == benchCyc, "R11", "cycle counter after reset", cycleCount, benchCyc);

    // R1: nothing pending after reset
    send(0, 0, 5, 2, 1, -1, 1'b1, 1, "R1");   expectStall(0, "R1");
    // R2: full write, data read next
    wr(1, 3, 1, "R2");
    send(2, 3, -1, -1, 1, -1, 1'b0, 1, "R2"); expectStall(0, "R2");
    // R3: address read directly after full write, high register
    wr(6, 3, 1, "R3");
    send(0, 3, 6, -1, -1, -1, 1'b1, 1, "R3"); expectStall(1, "R3");
    wr(7, 1, 1, "R3");
    send(0, 3, -1, 7, -1, -1, 1'b1, 1, "R3"); expectStall(1, "R3");
    // R4: address fields without address use
    wr(6, 3, 1, "R4");
    send(0, 3, 6, -1, -1, -1, 1'b0, 1, "R4"); expectStall(0, "R4");
    // R5: byte write then full read
    wr(0, 1, 1, "R5");
    send(4, 3, -1, -1, 0, -1, 1'b0, 1, "R5"); expectStall(1, "R5");
    wr(3, 2, 1, "R5");
    send(4, 3, -1, -1, -1, 3, 1'b0, 1, "R5"); expectStall(1, "R5");
    wr(5, 1, 1, "R5");
    send(4, 3, -1, -1, 5, -1, 1'b0, 1, "R5"); expectStall(0, "R5");
    // R6: both penalties on one operand
    wr(1, 1, 1, "R6");
    send(0, 1, 1, -1, -1, -1, 1'b1, 1, "R6"); expectStall(2, "R6");
    // R7: one intervening cycle, two, one two-cycle instruction, an idle cycle
    wr(1, 1, 1, "R7");
    wr(2, 3, 1, "R7");
    send(0, 1, 1, -1, -1, -1, 1'b1, 1, "R7"); expectStall(1, "R7");
    wr(1, 2, 1, "R7");
    wr(2, 3, 1, "R7");
    wr(5, 3, 1, "R7");
    send(0, 3, 1, -1, -1, -1, 1'b1, 1, "R7"); expectStall(0, "R7");
    wr(3, 1, 1, "R7");
    wr(5, 3, 2, "R7");
    send(0, 3, 3, -1, -1, -1, 1'b1, 1, "R7"); expectStall(0, "R7");
    wr(2, 1, 1, "R7");
    idle(1);
    send(0, 3, 2, -1, -1, -1, 1'b1, 1, "R7"); expectStall(1, "R7");
    // R8: full write clears byte state
    wr(2, 1, 1, "R8");
    wr(2, 3, 1, "R8");
    send(4, 3, -1, -1, 2, -1, 1'b0, 1, "R8"); expectStall(0, "R8");
    wr(2, 1, 1, "R8");
    wr(2, 3, 1, "R8");
    send(4, 3, 2, -1, -1, -1, 1'b1, 1, "R8"); expectStall(1, "R8");
    // R9: maximum over sources
    wr(3, 1, 1, "R9");
    wr(4, 3, 1, "R9");
    send(0, 3, 4, 3, -1, -1, 1'b1, 1, "R9"); expectStall(1, "R9");
    wr(2, 2, 1, "R9");
    send(0, 3, 2, -1, 7, -1, 1'b1, 1, "R9"); expectStall(2, "R9");
    // R10: multi-cycle producer, zero base, stalled multi-cycle consumer
    wr(6, 3, 3, "R10");
    send(0, 3, 6, -1, -1, -1, 1'b1, 1, "R10"); expectStall(1, "R10");
    wr(1, 1, 0, "R10");
    send(2, 3, 1, -1, -1, -1, 1'b1, 4, "R10"); expectStall(2, "R10");
    send(3, 3, -1, -1, 2, -1, 1'b0, 1, "R10"); expectStall(0, "R10");

    idle(12);
    check(expQ.size() == 0, "R10", "issue strobes outstanding", expQ.size(), 0);
    check(int'(cycleCount) == benchCyc, "R11", "cycle counter at end", cycleCount, benchCyc);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule